// File: doc/BRIEF.md
# Two-Dimensional Acoustic Mesh Stepper

This block advances a sampled 2D sound-pressure field by one time step on every enabled clock. The field is a rectangular array of identical cells. Each cell keeps two signed pressures: the value from the latest step and the value from the step before it. On a step, each cell takes half the sum of its four neighbours' latest pressures and subtracts its own older pressure. The scatter terms of the underlying wave-propagation model are folded into this single update, so no cell stores them. All cells update in the same clock edge.

A host clears the field, then sets the run enable. It can add one excitation sample per step at a selected node and read back one selected node through a registered observation port. A step counter reports how many steps have run since the last clear. Outside the grid, the field meets a rigid wall. The wall is modelled by letting each edge cell use its own latest pressure in place of any missing neighbour.

Top module: `mesh_array`

## Requirements
- R1: After the asynchronous reset or a synchronous clear, every cell pressure (latest and older) is zero and `step_cnt_o` is zero. After the clear, a read of any node returns 0.
- R2: On a step, a cell's new pressure is formed in three stages. First, the four neighbour values are sign-extended to DW+2 bits and summed. Second, the sum is arithmetically right-shifted by one, which rounds toward minus infinity (for example, -3 gives -2), and the low DW bits are kept. Third, the cell's older pressure is subtracted and any injected sample is added. The arithmetic is two's complement and wraps modulo 2^DW.
- R3: For a cell on the edge of the grid, each neighbour that lies outside the grid is replaced by that cell's own latest pressure.
- R4: While `run_i`=1 and `clear_i`=0, every cell updates on the same rising edge. Each cell's older pressure takes the previous latest value, so the whole field advances exactly one step per clock.
- R5: While `run_i`=0 and `clear_i`=0, no pressure and no counter bit changes, and `inj_data_i` has no effect.
- R6: On a step, `inj_data_i` is added only to the new pressure of node (row=`inj_row_i`, column=`inj_col_i`). Row 0 is the top edge and column 0 is the left edge.
- R7: On each rising edge, `obs_data_o` loads the latest pressure held just before that edge by node (`obs_row_i`, `obs_col_i`). A value therefore appears on the output one clock after the step that produced it.
- R8: `step_cnt_o` increases by one on each step and wraps modulo 2^CW.
- R9: When `clear_i`=1, the clear takes precedence over `run_i` and over injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the field and the counter |
| run_i | input | 1 | Step enable: one field step per clock while high |
| inj_row_i | input | RW | Row of the injection node |
| inj_col_i | input | CLW | Column of the injection node |
| inj_data_i | input | DW | Signed sample added to the injection node on a step |
| obs_row_i | input | RW | Row of the observation node |
| obs_col_i | input | CLW | Column of the observation node |
| obs_data_o | output | DW | Registered signed pressure of the observation node |
| step_cnt_o | output | CW | Number of steps since the last clear |

## Verification
The hardest behaviour to expose from the ports is the wall handling at a corner, together with the rounding of a negative odd neighbour sum. Both are masked once a long excitation has spread across the field. To reach them, the bench clears the field and injects a single impulse at a corner, then another at an interior node. It then stops stepping and walks the observation port over the neighbouring nodes, comparing against hand-computed values such as 100, 50 and -2. Long sine-burst and Gaussian runs are then compared step by step against an independent model of the recurrence, and each run is followed by a full-field scan.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  localparam int unsigned MESH_DW = 32;

  function automatic int unsigned cell_index(input int unsigned row, input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/mesh_cell.sv
module mesh_cell #(
  parameter int DW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 run_i,
  input  logic signed [DW-1:0] nb_n_i,
  input  logic signed [DW-1:0] nb_s_i,
  input  logic signed [DW-1:0] nb_e_i,
  input  logic signed [DW-1:0] nb_w_i,
  input  logic signed [DW-1:0] src_i,
  output logic signed [DW-1:0] p1_o
);
  logic signed [DW-1:0] p1_q, p2_q, p_new;
  logic signed [DW:0]   sum_ns, sum_ew;
  logic signed [DW+1:0] sum_all, half;

  // three 2-input adders, then shift, subtract, inject
  always_comb begin
    sum_ns  = {nb_n_i[DW-1], nb_n_i} + {nb_s_i[DW-1], nb_s_i};
    sum_ew  = {nb_e_i[DW-1], nb_e_i} + {nb_w_i[DW-1], nb_w_i};
    sum_all = {sum_ns[DW], sum_ns} + {sum_ew[DW], sum_ew};
    half    = sum_all >>> 1;
    p_new   = half[DW-1:0] - p2_q + src_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (clear_i) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (run_i) begin
      p2_q <= p1_q;
      p1_q <= p_new;
    end
  end

  assign p1_o = p1_q;

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(p1_o));

  a_r4_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i) |=> (p2_q == $past(p1_o)));

  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && nb_n_i == '0 && nb_s_i == '0 && nb_e_i == '0 && nb_w_i == '0
     && src_i == '0 && p2_q == '0) |=> (p1_o == '0));
endmodule

// File: rtl/mesh_obs_sel.sv
module mesh_obs_sel #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  parameter int DW   = 32,
  parameter int RW   = 5,
  parameter int CLW  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [RW-1:0]             row_i,
  input  logic [CLW-1:0]            col_i,
  input  logic [ROWS*COLS*DW-1:0]   field_i,
  output logic signed [DW-1:0]      obs_o
);
  localparam int NCELL = ROWS * COLS;

  int unsigned          idx;
  logic signed [DW-1:0] sel;

  always_comb begin
    idx = mesh_pkg::cell_index(int'(row_i), int'(col_i), COLS);
    sel = '0;
    if (idx < NCELL) sel = field_i[idx*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) obs_o <= '0;
    else         obs_o <= sel;
  end
endmodule

// File: rtl/mesh_step_ctr.sv
module mesh_step_ctr #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (run_i)   cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/mesh_array.sv
module mesh_array #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  parameter int DW   = mesh_pkg::MESH_DW,
  parameter int CW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 run_i,
  input  logic [RW-1:0]        inj_row_i,
  input  logic [CLW-1:0]       inj_col_i,
  input  logic signed [DW-1:0] inj_data_i,
  input  logic [RW-1:0]        obs_row_i,
  input  logic [CLW-1:0]       obs_col_i,
  output logic signed [DW-1:0] obs_data_o,
  output logic [CW-1:0]        step_cnt_o
);
  logic signed [DW-1:0]    p1_w [ROWS][COLS];
  logic [ROWS*COLS*DW-1:0] field_flat;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic signed [DW-1:0] nb_n, nb_s, nb_e, nb_w, src;

      // rigid wall: a missing neighbour mirrors the cell itself
      if (r == 0)        begin : g_wn assign nb_n = p1_w[r][c];   end
      else               begin : g_in assign nb_n = p1_w[r-1][c]; end
      if (r == ROWS - 1) begin : g_ws assign nb_s = p1_w[r][c];   end
      else               begin : g_is assign nb_s = p1_w[r+1][c]; end
      if (c == 0)        begin : g_ww assign nb_w = p1_w[r][c];   end
      else               begin : g_iw assign nb_w = p1_w[r][c-1]; end
      if (c == COLS - 1) begin : g_we assign nb_e = p1_w[r][c];   end
      else               begin : g_ie assign nb_e = p1_w[r][c+1]; end

      assign src = ((inj_row_i == RW'(r)) && (inj_col_i == CLW'(c))) ? inj_data_i : '0;

      mesh_cell #(.DW(DW)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(clear_i),
        .run_i  (run_i),
        .nb_n_i (nb_n),
        .nb_s_i (nb_s),
        .nb_e_i (nb_e),
        .nb_w_i (nb_w),
        .src_i  (src),
        .p1_o   (p1_w[r][c])
      );

      assign field_flat[(r*COLS+c)*DW +: DW] = p1_w[r][c];
    end
  end

  mesh_obs_sel #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RW(RW), .CLW(CLW)) u_obs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .row_i  (obs_row_i),
    .col_i  (obs_col_i),
    .field_i(field_flat),
    .obs_o  (obs_data_o)
  );

  mesh_step_ctr #(.CW(CW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .run_i  (run_i),
    .cnt_o  (step_cnt_o)
  );

  a_r8_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i) |=> (step_cnt_o == $past(step_cnt_o) + CW'(1)));

  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (step_cnt_o == '0 && p1_w[0][0] == '0));

  a_r1_clear_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |=> (obs_data_o == '0));
endmodule

// File: tb/mesh_array_tb.sv
module mesh_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int NC = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clear_i = 1'b0;
  logic              run_i = 1'b0;
  logic [4:0]        inj_row_i = '0;
  logic [4:0]        inj_col_i = '0;
  logic signed [31:0] inj_data_i = '0;
  logic [4:0]        obs_row_i = '0;
  logic [4:0]        obs_col_i = '0;
  logic signed [31:0] obs_data_o;
  logic [15:0]       step_cnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_steps = 0;
  logic signed [31:0] m1 [NR][NC];
  logic signed [31:0] m2 [NR][NC];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mesh_array u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .run_i(run_i),
    .inj_row_i(inj_row_i), .inj_col_i(inj_col_i), .inj_data_i(inj_data_i),
    .obs_row_i(obs_row_i), .obs_col_i(obs_col_i),
    .obs_data_o(obs_data_o), .step_cnt_o(step_cnt_o)
  );

  task automatic chk(input string req, input logic signed [31:0] act, input logic signed [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] mget(int r, int c, int rr, int cc);
    if (rr < 0 || rr >= NR || cc < 0 || cc >= NC) return m1[r][c];
    return m1[rr][cc];
  endfunction

  task automatic model_clear();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        m1[r][c] = '0;
        m2[r][c] = '0;
      end
    n_steps = 0;
  endtask

  task automatic model_step(int ir, int ic, logic signed [31:0] d);
    logic signed [31:0] nx [NR][NC];
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        logic signed [33:0] a, b, e, w, s, h;
        a = mget(r, c, r-1, c);
        b = mget(r, c, r+1, c);
        e = mget(r, c, r, c+1);
        w = mget(r, c, r, c-1);
        s = a + b + e + w;
        h = s >>> 1;
        nx[r][c] = h[31:0] - m2[r][c] + ((r == ir && c == ic) ? d : 32'sd0);
      end
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        m2[r][c] = m1[r][c];
        m1[r][c] = nx[r][c];
      end
    n_steps++;
  endtask

  // called at a negedge; returns at the next negedge with the pre-step obs value
  task automatic do_step(int ir, int ic, logic signed [31:0] d, output logic signed [31:0] snap);
    run_i = 1'b1;
    inj_row_i = 5'(ir);
    inj_col_i = 5'(ic);
    inj_data_i = d;
    snap = m1[obs_row_i][obs_col_i];
    model_step(ir, ic, d);
    @(negedge clk_i);
    run_i = 1'b0;
    inj_data_i = '0;
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    model_clear();
  endtask

  task automatic read_node(int r, int c, output logic signed [31:0] v);
    obs_row_i = 5'(r);
    obs_col_i = 5'(c);
    @(negedge clk_i);
    v = obs_data_o;
  endtask

  task automatic scan_field(string req);
    logic signed [31:0] v;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        read_node(r, c, v);
        chk(req, v, m1[r][c]);
      end
  endtask

  task automatic t_reset();
    chk("R1 counter after reset", 32'(step_cnt_o), 0);
    chk("R1 obs after reset", obs_data_o, 0);
  endtask

  task automatic t_neg_shift();
    logic signed [31:0] s, v;
    do_clear();
    do_step(5, 5, -32'sd3, s);
    do_step(0, 0, 32'sd0, s);
    read_node(5, 6, v); chk("R2 floor of -3/2", v, -32'sd2);
    read_node(4, 5, v); chk("R2 floor north", v, -32'sd2);
    read_node(5, 5, v); chk("R2 older subtract", v, 32'sd0);
    read_node(0, 0, v); chk("R6 non-selected node", v, 32'sd0);
    chk("R8 count after two steps", 32'(step_cnt_o), 2);
  endtask

  task automatic t_wall();
    logic signed [31:0] s, v;
    do_clear();
    do_step(0, 0, 32'sd100, s);
    do_step(0, 0, 32'sd0, s);
    read_node(0, 0, v); chk("R3 corner mirror", v, 32'sd100);
    read_node(0, 1, v); chk("R3 edge neighbour", v, 32'sd50);
    read_node(1, 0, v); chk("R3 edge neighbour col0", v, 32'sd50);
    read_node(31, 31, v); chk("R6 far corner untouched", v, 32'sd0);
  endtask

  task automatic t_hold();
    logic signed [31:0] v;
    logic [15:0] cnt0;
    cnt0 = step_cnt_o;
    run_i = 1'b0;
    inj_row_i = 5'd0; inj_col_i = 5'd0; inj_data_i = 32'sd999;
    repeat (3) @(negedge clk_i);
    inj_data_i = '0;
    chk("R5 counter held", 32'(step_cnt_o), 32'(cnt0));
    read_node(0, 0, v); chk("R5 injection ignored", v, m1[0][0]);
    read_node(0, 1, v); chk("R5 field held", v, m1[0][1]);
  endtask

  task automatic t_clear_prio();
    logic signed [31:0] v;
    run_i = 1'b1; clear_i = 1'b1;
    inj_row_i = 5'd3; inj_col_i = 5'd3; inj_data_i = 32'sd555;
    @(negedge clk_i);
    run_i = 1'b0; clear_i = 1'b0; inj_data_i = '0;
    model_clear();
    chk("R9 counter cleared", 32'(step_cnt_o), 0);
    read_node(3, 3, v); chk("R9 injection blocked", v, 32'sd0);
    scan_field("R1 field zero after clear");
  endtask

  task automatic t_burst(string name, bit gauss, int nstep);
    logic signed [31:0] s, d;
    real x;
    do_clear();
    obs_row_i = 5'd6; obs_col_i = 5'd15;
    @(negedge clk_i);
    for (int k = 0; k < nstep; k++) begin
      if (gauss) x = 1.0e8 * $exp(-((k - 20.0) * (k - 20.0)) / 50.0);
      else       x = (k < 16) ? 1.0e8 * $sin(2.0 * 3.14159265358979 * k / 16.0) : 0.0;
      d = 32'($rtoi(x));
      do_step(0, 0, d, s);
      chk({name, " R7 R4 obs node per step"}, obs_data_o, s);
    end
    chk({name, " R8 step count"}, 32'(step_cnt_o), n_steps);
    scan_field({name, " R3 R4 field scan"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_neg_shift();
    t_wall();
    t_hold();
    t_clear_prio();
    t_burst("sine", 1'b0, 400);
    t_hold();
    t_burst("gauss", 1'b1, 300);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule